// File: doc/BRIEF.md
# Time-of-Day Counter with Pulse-per-Second Output and Atomic Offset Adjustment

The block keeps time of day from a fixed reference clock. A sub-second counter counts reference cycles (8 ns each at 125 MHz) from zero up to one second minus one tick. A seconds counter sits above it. When the sub-second count rolls over, the seconds counter steps up and a pulse-per-second output is raised for a programmable number of ticks.

A timing servo outside this block corrects the time by loading a signed sub-second offset and a signed seconds offset through a simple register write/read port. It then writes the control word with both the enable and the adjust bits set. At the next enabled clock edge both offsets are added in that one edge. A carry or borrow from the sub-second result reaches the seconds counter in the same edge. The adjust bit then reads back as a completion flag.

Top module: `pps_timekeeper`

## Requirements
- R1: While enabled, the sub-second count goes up by one on each clock edge and always stays in the range 0 to TICKS_PER_SEC-1.
- R2: On an enabled edge where the sub-second count is TICKS_PER_SEC-1 and no adjustment is applied, the count goes to 0 and the seconds counter goes up by one.
- R3: After such a rollover, pps_out is high for exactly PW cycles, where PW is the control field at bits [8 +: PW_W]. The pulse covers the cycles in which the sub-second count is 0 to PW-1. With PW = 0 there is no pulse.
- R4: After reset both counters are 0 and pps_out is low. The control word reads enable 0, done 0 and PW = DEF_PW. All offset registers read 0.
- R5: While control bit 0 (enable) is 0, both counters hold their value and pps_out is low.
- R6: An adjustment starts only when the control word is written with bit 0 and bit 1 both at 1. Control read bit 1 reads 0 from that write until the adjustment is applied, and reads 1 after that. A control write with either bit at 0 applies no offset.
- R7: At the next enabled edge after the start, the sub-second count becomes old+1+offset and the seconds counter becomes old+seconds offset, both in that one edge. No PPS pulse starts on that edge.
- R8: If the sub-second result is TICKS_PER_SEC or more, TICKS_PER_SEC is subtracted and one more second is added. If the result is negative, TICKS_PER_SEC is added and one second is removed. The offset magnitude must be below TICKS_PER_SEC.
- R9: The register map is: 0 control, 1 signed sub-second offset, 2 sub-second count (read only), 4+i seconds offset word i, 8+i seconds count word i (word 0 is least significant). Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | DATA_W | Register read data, combinational from rd_addr |
| pps_out | output | 1 | Pulse-per-second output |

## Verification
The bench builds the block with TICKS_PER_SEC = 1000, DEF_PW = 40 and PW_W = 12, and keeps the full 64-bit seconds counter and 32-bit data path. A one-thousand-tick second makes rollovers, whole PPS pulses and both carry and borrow cases reachable in a few thousand cycles. The full seconds width lets an offset above 2^32 show up in the upper read word.

// File: rtl/pps_pkg.sv
package pps_pkg;
   localparam int unsigned REG_ADDR_W   = 4;
   localparam int unsigned CTRL_EN_BIT  = 0;
   localparam int unsigned CTRL_ADJ_BIT = 1;
   localparam int unsigned CTRL_PW_LSB  = 8;
   localparam int unsigned ADDR_CTRL    = 0;
   localparam int unsigned ADDR_SUB_OFF = 1;
   localparam int unsigned ADDR_SUB_CNT = 2;
   localparam int unsigned ADDR_SEC_OFF = 4;
   localparam int unsigned ADDR_SEC_CNT = 8;
   localparam int unsigned MAX_SEC_WORDS = 4;
endpackage

// File: rtl/pps_regs.sv
module pps_regs
   import pps_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned SEC_W  = 64,
   parameter int unsigned SUB_W  = 27,
   parameter int unsigned PW_W   = 20,
   parameter int unsigned DEF_PW = 100000
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [REG_ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic [REG_ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0]     rd_data,
   input  logic [SUB_W-1:0]      sub_cnt,
   input  logic [SEC_W-1:0]      sec_cnt,
   output logic                  en,
   output logic [PW_W-1:0]       pw,
   output logic [DATA_W-1:0]     sub_off,
   output logic [SEC_W-1:0]      sec_off,
   output logic                  apply
);
   localparam int unsigned SEC_WORDS = (SEC_W + DATA_W - 1) / DATA_W;
   localparam int unsigned SEC_PAD   = SEC_WORDS * DATA_W;

   logic              en_q, pending_q, done_q;
   logic [PW_W-1:0]   pw_q;
   logic [DATA_W-1:0] sub_off_q;
   logic [SEC_PAD-1:0] sec_off_pad;
   logic [SEC_PAD-1:0] sec_cnt_pad;
   logic              ctrl_wr, start;

   assign ctrl_wr = wr_en && (wr_addr == REG_ADDR_W'(ADDR_CTRL));
   assign start   = ctrl_wr && wr_data[CTRL_EN_BIT] && wr_data[CTRL_ADJ_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         pw_q      <= PW_W'(DEF_PW);
         sub_off_q <= '0;
         pending_q <= 1'b0;
         done_q    <= 1'b0;
      end else begin
         if (ctrl_wr) begin
            en_q <= wr_data[CTRL_EN_BIT];
            pw_q <= wr_data[CTRL_PW_LSB +: PW_W];
         end
         if (wr_en && (wr_addr == REG_ADDR_W'(ADDR_SUB_OFF)))
            sub_off_q <= wr_data;
         if (start) begin
            pending_q <= 1'b1;
            done_q    <= 1'b0;
         end else if (pending_q && en_q) begin
            pending_q <= 1'b0;
            done_q    <= 1'b1;
         end
      end
   end

   for (genvar w = 0; w < SEC_WORDS; w++) begin : g_sec_word
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q <= '0;
         else if (wr_en && (wr_addr == REG_ADDR_W'(ADDR_SEC_OFF + w)))
            word_q <= wr_data;
      end
      assign sec_off_pad[w*DATA_W +: DATA_W] = word_q;
   end

   assign sec_cnt_pad = SEC_PAD'(sec_cnt);

   always_comb begin
      rd_data = '0;
      if (rd_addr == REG_ADDR_W'(ADDR_CTRL)) begin
         rd_data[CTRL_EN_BIT]            = en_q;
         rd_data[CTRL_ADJ_BIT]           = done_q;
         rd_data[CTRL_PW_LSB +: PW_W]    = pw_q;
      end else if (rd_addr == REG_ADDR_W'(ADDR_SUB_OFF)) begin
         rd_data = sub_off_q;
      end else if (rd_addr == REG_ADDR_W'(ADDR_SUB_CNT)) begin
         rd_data = DATA_W'(sub_cnt);
      end
      for (int w = 0; w < SEC_WORDS; w++) begin
         if (rd_addr == REG_ADDR_W'(ADDR_SEC_OFF + w))
            rd_data = sec_off_pad[w*DATA_W +: DATA_W];
         if (rd_addr == REG_ADDR_W'(ADDR_SEC_CNT + w))
            rd_data = sec_cnt_pad[w*DATA_W +: DATA_W];
      end
   end

   assign en      = en_q;
   assign pw      = pw_q;
   assign sub_off = sub_off_q;
   assign sec_off = sec_off_pad[SEC_W-1:0];
   assign apply   = pending_q && en_q;
endmodule

// File: rtl/pps_adjust_calc.sv
module pps_adjust_calc #(
   parameter int unsigned TICKS_PER_SEC = 125000000,
   parameter int unsigned SUB_W         = 27,
   parameter int unsigned DATA_W        = 32
) (
   input  logic [SUB_W-1:0]  sub_cur,
   input  logic [DATA_W-1:0] offset,
   output logic [SUB_W-1:0]  sub_next,
   output logic              carry,
   output logic              borrow
);
   localparam int unsigned CW = DATA_W + 2;
   localparam logic signed [CW-1:0] TPS_S = CW'(TICKS_PER_SEC);
   localparam logic signed [CW-1:0] ONE_S = CW'(1);

   logic signed [CW-1:0] sum, fixed;
   logic                 unused_hi;

   always_comb begin
      sum    = $signed(CW'(sub_cur)) + $signed({{2{offset[DATA_W-1]}}, offset}) + ONE_S;
      carry  = 1'b0;
      borrow = 1'b0;
      fixed  = sum;
      if (sum >= TPS_S) begin
         carry = 1'b1;
         fixed = sum - TPS_S;
      end else if (sum < 0) begin
         borrow = 1'b1;
         fixed  = sum + TPS_S;
      end
   end

   assign sub_next  = fixed[SUB_W-1:0];
   assign unused_hi = ^fixed[CW-1:SUB_W];
endmodule

// File: rtl/pps_time_core.sv
module pps_time_core #(
   parameter int unsigned TICKS_PER_SEC = 125000000,
   parameter int unsigned SUB_W         = 27,
   parameter int unsigned SEC_W         = 64,
   parameter int unsigned PW_W          = 20,
   parameter int unsigned DATA_W        = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [PW_W-1:0]   pw,
   input  logic              apply,
   input  logic [DATA_W-1:0] sub_off,
   input  logic [SEC_W-1:0]  sec_off,
   output logic [SUB_W-1:0]  sub_cnt,
   output logic [SEC_W-1:0]  sec_cnt,
   output logic              pps
);
   localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICKS_PER_SEC - 1);

   logic [SUB_W-1:0] sub_q, adj_sub;
   logic [SEC_W-1:0] sec_q;
   logic [PW_W-1:0]  pulse_left;
   logic             adj_carry, adj_borrow, wrap;

   pps_adjust_calc #(
      .TICKS_PER_SEC(TICKS_PER_SEC),
      .SUB_W        (SUB_W),
      .DATA_W       (DATA_W)
   ) i_calc (
      .sub_cur (sub_q),
      .offset  (sub_off),
      .sub_next(adj_sub),
      .carry   (adj_carry),
      .borrow  (adj_borrow)
   );

   assign wrap = (sub_q == SUB_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub_q      <= '0;
         sec_q      <= '0;
         pulse_left <= '0;
      end else if (!en) begin
         pulse_left <= '0;
      end else begin
         if (pulse_left != '0)
            pulse_left <= pulse_left - PW_W'(1);
         if (apply) begin
            sub_q <= adj_sub;
            sec_q <= sec_q + sec_off + SEC_W'(adj_carry) - SEC_W'(adj_borrow);
         end else if (wrap) begin
            sub_q      <= '0;
            sec_q      <= sec_q + SEC_W'(1);
            pulse_left <= pw;
         end else begin
            sub_q <= sub_q + SUB_W'(1);
         end
      end
   end

   assign sub_cnt = sub_q;
   assign sec_cnt = sec_q;
   assign pps     = (pulse_left != '0);
endmodule

// File: rtl/pps_timekeeper.sv
module pps_timekeeper
   import pps_pkg::*;
#(
   parameter int unsigned TICKS_PER_SEC = 125000000,
   parameter int unsigned SEC_W         = 64,
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned PW_W          = 20,
   parameter int unsigned DEF_PW        = 100000
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [REG_ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic [REG_ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0]     rd_data,
   output logic                  pps_out
);
   localparam int unsigned SUB_W     = $clog2(TICKS_PER_SEC);
   localparam int unsigned SEC_WORDS = (SEC_W + DATA_W - 1) / DATA_W;

   if (TICKS_PER_SEC < 2) begin : g_bad_tps
      $error("TICKS_PER_SEC must be at least 2");
   end
   if (64'(TICKS_PER_SEC) >= (64'd1 << (DATA_W - 1))) begin : g_bad_off_w
      $error("TICKS_PER_SEC must fit the signed offset range");
   end
   if (CTRL_PW_LSB + PW_W > DATA_W) begin : g_bad_pw_w
      $error("pulse width field does not fit the control word");
   end
   if (64'(DEF_PW) >= (64'd1 << PW_W)) begin : g_bad_def_pw
      $error("DEF_PW does not fit PW_W bits");
   end
   if (SEC_WORDS > MAX_SEC_WORDS) begin : g_bad_sec_w
      $error("SEC_W needs more register words than the map holds");
   end

   logic              ctrl_en, adj_apply;
   logic [PW_W-1:0]   ctrl_pw;
   logic [DATA_W-1:0] sub_off;
   logic [SEC_W-1:0]  sec_off, sec_cnt;
   logic [SUB_W-1:0]  sub_cnt;

   pps_regs #(
      .DATA_W(DATA_W),
      .SEC_W (SEC_W),
      .SUB_W (SUB_W),
      .PW_W  (PW_W),
      .DEF_PW(DEF_PW)
   ) i_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .rd_addr(rd_addr),
      .rd_data(rd_data),
      .sub_cnt(sub_cnt),
      .sec_cnt(sec_cnt),
      .en     (ctrl_en),
      .pw     (ctrl_pw),
      .sub_off(sub_off),
      .sec_off(sec_off),
      .apply  (adj_apply)
   );

   pps_time_core #(
      .TICKS_PER_SEC(TICKS_PER_SEC),
      .SUB_W        (SUB_W),
      .SEC_W        (SEC_W),
      .PW_W         (PW_W),
      .DATA_W       (DATA_W)
   ) i_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (ctrl_en),
      .pw     (ctrl_pw),
      .apply  (adj_apply),
      .sub_off(sub_off),
      .sec_off(sec_off),
      .sub_cnt(sub_cnt),
      .sec_cnt(sec_cnt),
      .pps    (pps_out)
   );
endmodule

// File: rtl/pps_timekeeper_chk.sv
module pps_timekeeper_chk
   import pps_pkg::*;
#(
   parameter int unsigned TICKS_PER_SEC = 125000000,
   parameter int unsigned SUB_W         = 27,
   parameter int unsigned SEC_W         = 64
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  en,
   input logic                  apply,
   input logic                  wr_en,
   input logic [REG_ADDR_W-1:0] wr_addr,
   input logic [1:0]            ctl_bits,
   input logic [SUB_W-1:0]      sub,
   input logic [SEC_W-1:0]      sec,
   input logic                  pps
);
   localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICKS_PER_SEC - 1);

   logic start;
   assign start = wr_en && (wr_addr == REG_ADDR_W'(ADDR_CTRL)) && (&ctl_bits);

   AST_SUB_RANGE: assert property (@(posedge clk) disable iff (!rst_n) sub <= SUB_LAST); // R1
   AST_SUB_STEP: assert property (@(posedge clk) disable iff (!rst_n) en && !apply && sub != SUB_LAST |=> sub == $past(sub) + SUB_W'(1)); // R1
   AST_SEC_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n) en && !apply && sub == SUB_LAST |=> sub == '0 && sec == $past(sec) + SEC_W'(1)); // R2
   AST_PPS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) $rose(pps) |-> sub == '0); // R3
   AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n) !en |=> $stable(sub) && $stable(sec) && !pps); // R5
   AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n) start |=> apply); // R6
   AST_APPLY_ONCE: assert property (@(posedge clk) disable iff (!rst_n) apply && !start |=> !apply); // R6
   AST_NO_PULSE_ON_ADJ: assert property (@(posedge clk) disable iff (!rst_n) apply |=> !$rose(pps)); // R7
endmodule

bind pps_timekeeper pps_timekeeper_chk #(
   .TICKS_PER_SEC(TICKS_PER_SEC),
   .SUB_W        (SUB_W),
   .SEC_W        (SEC_W)
) i_pps_timekeeper_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .en      (ctrl_en),
   .apply   (adj_apply),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .ctl_bits(wr_data[1:0]),
   .sub     (sub_cnt),
   .sec     (sec_cnt),
   .pps     (pps_out)
);

// File: tb/test_pps_timekeeper.sv
`timescale 1ns/100ps
module test_pps_timekeeper;
   localparam int TPS    = 1000;
   localparam int PW     = 40;
   localparam int PW_W   = 12;
   localparam int SEC_W  = 64;
   localparam int DATA_W = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [3:0]        wr_addr = '0;
   logic [DATA_W-1:0] wr_data = '0;
   logic [3:0]        rd_addr = '0;
   logic [DATA_W-1:0] rd_data;
   logic              pps_out;

   int     n_chk = 0;
   int     n_fail = 0;
   bit     finished = 0;
   int     exp_sub = 0;
   longint exp_sec = 0;
   int     cur_pw = PW;

   always #2 clk = ~clk;

   pps_timekeeper #(
      .TICKS_PER_SEC(TPS),
      .SEC_W        (SEC_W),
      .DATA_W       (DATA_W),
      .PW_W         (PW_W),
      .DEF_PW       (PW)
   ) i_pps_timekeeper (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .rd_addr(rd_addr),
      .rd_data(rd_data),
      .pps_out(pps_out)
   );

   function automatic logic [31:0] ctrl_word(bit en, bit adj, int pw);
      return (32'(pw) << 8) | {30'b0, adj, en};
   endfunction

   task automatic chk(input string msg, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", msg, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
      rd_addr = a;
      #0.2;
      d = rd_data;
   endtask

   task automatic adv(input int k);
      for (int i = 0; i < k; i++) begin
         if (exp_sub == TPS - 1) begin exp_sub = 0; exp_sec++; end
         else exp_sub++;
      end
   endtask

   task automatic check_time(input string req);
      logic [31:0] s, lo, hi;
      reg_rd(2, s); reg_rd(8, lo); reg_rd(9, hi);
      chk({req, " sub-second count"}, 64'(s), 64'(exp_sub));
      chk({req, " seconds count"}, {hi, lo}, exp_sec);
   endtask

   task automatic run(input int k);
      reg_wr(0, ctrl_word(1, 0, cur_pw));
      repeat (k - 1) @(negedge clk);
      reg_wr(0, ctrl_word(0, 0, cur_pw));
      adv(k);
   endtask

   task automatic apply_adj(input string req, input longint off_sub, input longint off_sec);
      logic [31:0] r;
      longint s, c;
      reg_wr(1, 32'(off_sub));
      reg_wr(4, off_sec[31:0]);
      reg_wr(5, off_sec[63:32]);
      reg_wr(0, ctrl_word(1, 1, cur_pw));
      reg_rd(0, r);
      chk({req, " R6 done reads 0 while pending"}, 64'(r[1]), 64'd0);
      reg_wr(0, ctrl_word(0, 0, cur_pw));
      s = longint'(exp_sub) + 1 + off_sub;
      c = 0;
      if (s >= TPS) begin s -= TPS; c = 1; end
      else if (s < 0) begin s += TPS; c = -1; end
      exp_sub = int'(s);
      exp_sec = exp_sec + off_sec + c;
      reg_rd(0, r);
      chk({req, " R6 done reads 1 after apply"}, 64'(r[1]), 64'd1);
      check_time(req);
      chk({req, " R7 no pulse on adjust"}, 64'(pps_out), 64'd0);
   endtask

   task automatic t_reset();
      logic [31:0] r;
      reg_rd(0, r);
      chk("R4 control reset value", 64'(r), 64'(ctrl_word(0, 0, PW)));
      reg_rd(1, r);
      chk("R4 sub offset reset", 64'(r), 64'd0);
      reg_rd(4, r);
      chk("R4 sec offset reset", 64'(r), 64'd0);
      check_time("R4");
      chk("R4 pps low", 64'(pps_out), 64'd0);
   endtask

   task automatic t_count();
      run(10);
      check_time("R1 count 10");
      repeat (5) @(negedge clk);
      check_time("R5 hold while disabled");
      chk("R5 pps low while disabled", 64'(pps_out), 64'd0);
   endtask

   task automatic t_wrap();
      run(TPS - 1 - exp_sub);
      check_time("R1 reach last tick");
      reg_wr(0, ctrl_word(1, 0, cur_pw));
      for (int k = 1; k <= PW + 3; k++) begin
         @(negedge clk);
         adv(1);
         if (k == 1) check_time("R2 rollover");
         chk($sformatf("R3 pps at tick %0d", exp_sub), 64'(pps_out), 64'(exp_sub < PW));
      end
      reg_wr(0, ctrl_word(0, 0, cur_pw));
      adv(1);
      check_time("R1 after pulse");
   endtask

   task automatic t_zero_pw();
      cur_pw = 0;
      reg_wr(0, ctrl_word(0, 0, 0));
      run(TPS - 1 - exp_sub);
      reg_wr(0, ctrl_word(1, 0, 0));
      for (int k = 1; k <= 5; k++) begin
         @(negedge clk);
         adv(1);
         chk("R3 zero width gives no pulse", 64'(pps_out), 64'd0);
      end
      reg_wr(0, ctrl_word(0, 0, 0));
      adv(1);
      check_time("R2 rollover with zero width");
      cur_pw = PW;
      reg_wr(0, ctrl_word(0, 0, PW));
   endtask

   task automatic t_ignored();
      logic [31:0] r;
      reg_wr(1, 32'd50);
      reg_wr(0, ctrl_word(0, 1, PW));
      reg_rd(0, r);
      chk("R6 adjust without enable starts nothing", 64'(r), 64'(ctrl_word(0, 1, PW)));
      check_time("R6 counters untouched");
      run(1);
      check_time("R6 enable without adjust adds no offset");
      reg_rd(0, r);
      chk("R6 done stays set", 64'(r[1]), 64'd1);
   endtask

   task automatic t_regmap();
      logic [31:0] r;
      reg_rd(1, r);
      chk("R9 sub offset readback", 64'(r), 64'd50);
      reg_rd(5, r);
      chk("R9 sec offset high word", 64'(r), 64'd1);
      reg_rd(3, r);
      chk("R9 unmapped address 3", 64'(r), 64'd0);
      reg_rd(6, r);
      chk("R9 unmapped address 6", 64'(r), 64'd0);
      reg_rd(15, r);
      chk("R9 unmapped address 15", 64'(r), 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_count();
      t_wrap();
      t_zero_pw();
      apply_adj("R7 plain adjust", 100, 5);
      apply_adj("R8 carry", longint'(TPS - exp_sub + 3), 0);
      apply_adj("R8 borrow", -longint'(exp_sub + 5), -2);
      apply_adj("R7 wide seconds offset", 0, 64'h1_0000_0003);
      t_ignored();
      t_regmap();
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule